// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 64 pins. The pins are split into two banks of 32. Pins 0 to 31 belong to the low bank. Pin `p` at 32 or above is bit `p - 32` of the high bank. Each bank has eight word registers:

- data out
- an active-low output enable (output disable)
- blink enable
- input inversion
- data in
- edge interrupt mask
- level interrupt mask
- interrupt cause

Software reaches the registers through a plain 32-bit write port with a combinational read port. The pads connect through the pin input, output and output-enable vectors. A single interrupt line covers both banks.

Pin inputs pass through a two-flop synchronizer. They are then XORed with the inversion bit, and the result feeds the data-in readback and the interrupt logic. An edge cause bit latches a rising edge of the adjusted input. A level cause bit tracks the adjusted input while its level mask is set. Software clears a cause bit by writing zero to it. A blinking output follows a phase signal that all blinking pins share, in place of its data-out bit.

Top module: `banked_gpio`

## Requirements
- R1: The register address is `regAddr`. Bit 3 selects the bank (0 low, 1 high), and bits 2:0 select the register: 0 data out, 1 output disable, 2 blink enable, 3 input invert, 4 data in, 5 edge mask, 6 level mask, 7 cause. Pin `p` is bit `p mod 32` of bank `p / 32`. A write with `regWrEn` high takes effect at the next clock edge, and `regRdData` shows the addressed register combinationally.
- R2: After reset, data out, blink enable, input invert, both masks, every cause bit and `irqOut` are 0. Every output-disable bit is 1, so `pinOutEn` is all zero.
- R3: `pinOutEn[p]` is the inverse of output-disable bit `p`. Writing 0 to that bit makes the pin drive.
- R4: Data in reads the synchronized pin value XOR its input-invert bit.
- R5: When blink enable bit `p` is set, `pinOut[p]` follows a phase that all blinking pins share. The phase flips once every `BLINK_DIV` clock cycles. Otherwise `pinOut[p]` equals data-out bit `p`.
- R6: A rising edge of the adjusted input sets the pin's cause bit whatever its masks hold. The bit stays set until software clears it.
- R7: While level mask bit `p` is set, cause bit `p` copies the adjusted input every cycle, and writes to that bit have no effect.
- R8: Writing 0 to a cause bit clears it, and writing 1 leaves it unchanged. If a rising edge arrives in the same cycle as a clearing write, the bit stays set.
- R9: `irqOut` is a register. It becomes 1 one cycle after any cause bit is set whose edge mask or level mask is set, and 0 one cycle after none is.
- R10: High-bank bits for pins at or above `NUM_PINS` read as 0, and writes to them are ignored. With `NUM_PINS` of 32 or less, no high bank exists. The data-in register ignores writes.
- R11: A pin change is visible in data in after two clock edges. The cause bit sets on the third edge and `irqOut` rises on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Bank bit and register index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed register |
| pinIn | input | NUM_PINS | Pad input values |
| pinOut | output | NUM_PINS | Pad output values |
| pinOutEn | output | NUM_PINS | Pad drive enables, active high |
| irqOut | output | 1 | Combined interrupt |

## Verification
A software write that clears the cause register can land in the same cycle that a synchronized rising edge reaches the edge detector. The bench provokes this by raising pin 5 and timing a write of all zeros to the cause register so that it commits on the third clock edge after the pin change. That is the same edge on which the new event registers. The expected outcome is that bit 5 survives, while bit 6, which was pending with no new event, is cleared. A second collision pairs a clearing write with a pin that has its level mask set; there the level value must win.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;
  localparam int BANK_W   = 32;
  localparam int NUM_REGS = 8;

  typedef enum logic [2:0] {
    RS_DOUT  = 3'd0,
    RS_ODIS  = 3'd1,
    RS_BLINK = 3'd2,
    RS_INV   = 3'd3,
    RS_DIN   = 3'd4,
    RS_EDGE  = 3'd5,
    RS_LEVEL = 3'd6,
    RS_CAUSE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic                wrBank;
    logic [NUM_REGS-1:0] wrHit;
    logic                rdBank;
    regSel_e             rdSel;
    logic                blinkPhase;
  } ctrlStrobe_t;

  typedef struct packed {
    logic dOut;
    logic oDis;
    logic blink;
    logic inv;
    logic edgeM;
    logic levM;
    logic cause;
    logic s1;
    logic s2;
    logic prev;
  } pinState_t;
endpackage

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import banked_gpio_pkg::*;
#(
  parameter int BLINK_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  output ctrlStrobe_t strb
);
  localparam int CNT_W = (BLINK_DIV > 2) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_DIV - 1);

  logic [CNT_W-1:0]    divCnt;
  logic                phase;
  logic [NUM_REGS-1:0] hitRaw;

  // decode: one strobe per register, data-in is read-only
  always_comb begin
    hitRaw = '0;
    if (regWrEn) hitRaw = NUM_REGS'(1) << regAddr[2:0];
    hitRaw[RS_DIN] = 1'b0;
  end

  assign strb.wrBank     = regAddr[3];
  assign strb.wrHit      = hitRaw;
  assign strb.rdBank     = regAddr[3];
  assign strb.rdSel      = regSel_e'(regAddr[2:0]);
  assign strb.blinkPhase = phase;

  // shared blink timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (divCnt == CNT_LAST) begin
      divCnt <= '0;
      phase  <= ~phase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R5
  blink_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt != CNT_LAST) |=> $stable(phase));
  // R5
  blink_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt == CNT_LAST) |=> (phase != $past(phase)));
  // R1
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrHit));
endmodule

// File: rtl/banked_gpio_dp.sv
module banked_gpio_dp
  import banked_gpio_pkg::*;
#(
  parameter int NUM_PINS = 50
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [BANK_W-1:0]   wrData,
  output logic [BANK_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);
  localparam int LO_W = (NUM_PINS < BANK_W) ? NUM_PINS : BANK_W;

  pinState_t           st [NUM_PINS];
  logic [NUM_PINS-1:0] adjVec, evtVec, causeVec, edgeVec, levVec;
  logic [NUM_REGS-1:0] pinView [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int BK = i / BANK_W;
    localparam int BT = i % BANK_W;
    logic bankHit, adj, evt, clrNow;

    assign bankHit = (strb.wrBank == BK[0]);
    assign adj     = st[i].s2 ^ st[i].inv;
    assign evt     = adj & ~st[i].prev;
    assign clrNow  = bankHit & strb.wrHit[RS_CAUSE] & ~wrData[BT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st[i] <= '{oDis: 1'b1, default: 1'b0};
      end else begin
        st[i].s1   <= pinIn[i];
        st[i].s2   <= st[i].s1;
        st[i].prev <= adj;
        if (bankHit & strb.wrHit[RS_DOUT])  st[i].dOut  <= wrData[BT];
        if (bankHit & strb.wrHit[RS_ODIS])  st[i].oDis  <= wrData[BT];
        if (bankHit & strb.wrHit[RS_BLINK]) st[i].blink <= wrData[BT];
        if (bankHit & strb.wrHit[RS_INV])   st[i].inv   <= wrData[BT];
        if (bankHit & strb.wrHit[RS_EDGE])  st[i].edgeM <= wrData[BT];
        if (bankHit & strb.wrHit[RS_LEVEL]) st[i].levM  <= wrData[BT];
        if (st[i].levM) st[i].cause <= adj;
        else            st[i].cause <= (st[i].cause & ~clrNow) | evt;
      end
    end

    assign adjVec[i]   = adj;
    assign evtVec[i]   = evt;
    assign causeVec[i] = st[i].cause;
    assign edgeVec[i]  = st[i].edgeM;
    assign levVec[i]   = st[i].levM;
    assign pinOut[i]   = st[i].blink ? strb.blinkPhase : st[i].dOut;
    assign pinOutEn[i] = ~st[i].oDis;
    assign pinView[i]  = {st[i].cause, st[i].levM, st[i].edgeM, adj,
                          st[i].inv, st[i].blink, st[i].oDis, st[i].dOut};
  end

  // readback: each word bit picks its low- or high-bank pin
  for (genvar b = 0; b < BANK_W; b++) begin : g_rd
    logic loBit, hiBit;
    if (b < NUM_PINS) begin : g_lo
      assign loBit = pinView[b][strb.rdSel];
    end else begin : g_lo0
      assign loBit = 1'b0;
    end
    if (b + BANK_W < NUM_PINS) begin : g_hi
      assign hiBit = pinView[b + BANK_W][strb.rdSel];
    end else begin : g_hi0
      assign hiBit = 1'b0;
    end
    assign rdData[b] = strb.rdBank ? hiBit : loBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(causeVec & (edgeVec | levVec));
  end

  // R3
  oe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit[RS_ODIS] && !strb.wrBank)
      |=> (pinOutEn[LO_W-1:0] == ~$past(wrData[LO_W-1:0])));
  // R6
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((causeVec & $past(evtVec)) == $past(evtVec)));
  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((causeVec ^ $past(adjVec)) & $past(levVec)) == '0);
  // R8
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit[RS_CAUSE] && !strb.wrBank && evtVec[LO_W-1:0] == '0 && levVec[LO_W-1:0] == '0)
      |=> (causeVec[LO_W-1:0] == $past(causeVec[LO_W-1:0] & wrData[LO_W-1:0])));
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(causeVec & (edgeVec | levVec))));
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import banked_gpio_pkg::*;
#(
  parameter int NUM_PINS  = 50,
  parameter int BLINK_DIV = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                irqOut
);
  ctrlStrobe_t strb;

  banked_gpio_ctrl #(.BLINK_DIV(BLINK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb)
  );

  banked_gpio_dp #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .rdData(regRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );
endmodule

// File: tb/banked_gpio_tb.sv
`timescale 1ns/1ps
module banked_gpio_tb_top;
  localparam int NP  = 50;
  localparam int DIV = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOutEn;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  banked_gpio #(.NUM_PINS(NP), .BLINK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  // {address, write data, expected readback}
  localparam logic [67:0] TBL [10] = '{
    {4'h0, 32'hA5A50F0F, 32'hA5A50F0F},  // R1 low data out
    {4'h8, 32'hFFFFFFFF, 32'h0003FFFF},  // R10 high data out, 18 pins
    {4'h1, 32'h12345678, 32'h12345678},  // R3 low output disable
    {4'h9, 32'h00000000, 32'h00000000},  // R3 high output disable
    {4'h2, 32'h00000000, 32'h00000000},  // R1 low blink
    {4'hA, 32'hFFFFFFFF, 32'h0003FFFF},  // R10 high blink
    {4'h5, 32'h00000000, 32'h00000000},  // R1 low edge mask
    {4'h7, 32'hFFFFFFFF, 32'h00000000},  // R8 writing ones sets nothing
    {4'h4, 32'hFFFFFFFF, 32'h00000000},  // R10 data in is read-only
    {4'hE, 32'hFFFFFFFF, 32'h0003FFFF}   // R10 high level mask
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = '0; regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int lastChg, prevVal, misShare, misHold;

    // R2 reset state
    doReset();
    chk("R2 irq", 64'(irqOut), 64'd0);
    chk("R2 oe", 64'(pinOutEn), 64'd0);
    chk("R2 out", 64'(pinOut), 64'd0);
    regRead(4'h1, rd); chk("R2 odis", 64'(rd), 64'hFFFFFFFF);
    regRead(4'h5, rd); chk("R2 edge", 64'(rd), 64'd0);
    regRead(4'hE, rd); chk("R2 level hi", 64'(rd), 64'd0);
    regRead(4'h7, rd); chk("R2 cause", 64'(rd), 64'd0);

    // R1 R10 table walk
    for (int k = 0; k < 10; k++) begin
      regWrite(TBL[k][67:64], TBL[k][63:32]);
      regRead(TBL[k][67:64], rd);
      chk("R1 table", 64'(rd), 64'(TBL[k][31:0]));
    end
    chk("R3 pin enables", 64'(pinOutEn), {14'd0, 18'h3FFFF, ~32'h12345678});
    chk("R5 no blink low", 64'(pinOut[31:0]), 64'hA5A50F0F);

    // R4 polarity, R11 latency
    doReset();
    pinIn[3] = 1'b1;
    @(negedge clk);
    regRead(4'h4, rd); chk("R11 after one edge", 64'(rd), 64'd0);
    @(negedge clk);
    regRead(4'h4, rd); chk("R11 after two edges", 64'(rd), 64'h8);
    regWrite(4'h3, 32'h9);
    regRead(4'h4, rd); chk("R4 inverted", 64'(rd), 64'h1);
    pinIn[40] = 1'b1;
    repeat (3) @(negedge clk);
    regRead(4'hC, rd); chk("R10 high data in", 64'(rd), 64'h100);

    // R6 R8 R9 edge interrupts
    doReset();
    regWrite(4'h5, 32'h20);
    pinIn[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    regRead(4'h7, rd); chk("R11 cause not yet", 64'(rd), 64'd0);
    @(negedge clk);
    regRead(4'h7, rd); chk("R6 edge cause", 64'(rd), 64'h20);
    chk("R11 irq not yet", 64'(irqOut), 64'd0);
    @(negedge clk);
    chk("R9 irq up", 64'(irqOut), 64'd1);
    pinIn[6] = 1'b1;
    repeat (4) @(negedge clk);
    regRead(4'h7, rd); chk("R6 unmasked cause", 64'(rd), 64'h60);
    pinIn[5] = 1'b0;
    repeat (4) @(negedge clk);
    regRead(4'h7, rd); chk("R6 falling keeps", 64'(rd), 64'h60);
    regWrite(4'h7, 32'hFFFFFFDF);
    regRead(4'h7, rd); chk("R8 clear bit", 64'(rd), 64'h40);
    @(negedge clk);
    chk("R9 irq down unmasked", 64'(irqOut), 64'd0);

    // R8 collision: clearing write commits on the edge that sees the event
    @(negedge clk);
    pinIn[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'h7; regWrData = 32'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    regRead(4'h7, rd); chk("R8 event beats clear", 64'(rd), 64'h20);

    // R7 level
    regWrite(4'h6, 32'h80);
    pinIn[7] = 1'b1;
    repeat (4) @(negedge clk);
    regRead(4'h7, rd); chk("R7 level set", 64'(rd), 64'hA0);
    regWrite(4'h7, 32'h0);
    regRead(4'h7, rd); chk("R7 level ignores clear", 64'(rd), 64'h80);
    pinIn[7] = 1'b0;
    repeat (4) @(negedge clk);
    regRead(4'h7, rd); chk("R7 level follows", 64'(rd), 64'h0);
    chk("R9 irq idle", 64'(irqOut), 64'd0);

    // R10 high bank edge
    regWrite(4'hD, 32'h200);
    pinIn[41] = 1'b1;
    repeat (5) @(negedge clk);
    regRead(4'hF, rd); chk("R10 high cause", 64'(rd), 64'h200);
    chk("R9 irq high bank", 64'(irqOut), 64'd1);

    // R5 blink
    doReset();
    regWrite(4'h0, 32'h2);
    regWrite(4'h2, 32'h5);
    lastChg = -1; prevVal = int'(pinOut[0]); misShare = 0; misHold = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (pinOut[2] !== pinOut[0]) misShare++;
      if (pinOut[1] !== 1'b1) misHold++;
      if (int'(pinOut[0]) != prevVal) begin
        if (lastChg >= 0) chk("R5 period", 64'(t - lastChg), 64'(DIV));
        lastChg = t;
        prevVal = int'(pinOut[0]);
      end
    end
    chk("R5 shared phase", 64'(misShare), 64'd0);
    chk("R5 non-blink holds", 64'(misHold), 64'd0);

    finishRun();
  end
endmodule